// File: doc/BRIEF.md
# Closed-Loop Toggle Handshake Word Synchronizer

This block moves one multi-bit data word at a time between two clock domains that share no timing relationship. The source domain loads a word into a holding register and announces it by flipping a request level. The destination domain passes that level through a multi-flop synchronizer and rebuilds it into a single-cycle pulse. On that pulse it samples the held word into its output register and flips an acknowledge level in return.

The acknowledge level travels back through its own synchronizer and is rebuilt into a pulse in the source domain. That pulse retires the transfer. The source reports `src_busy` for the whole round trip and accepts no new word until it ends. The data bus is never synchronized bit by bit: it is only sampled while it is held stable. No frequency ratio is assumed in either direction, so the block suits fast-to-slow and slow-to-fast crossings alike.

Top module: `cdc_toggle_handshake`

## Requirements
- R1: After reset, `src_busy`, `src_overrun` and `dst_valid` are 0, and `dst_data` is all zeros. No `dst_valid` pulse appears until a word has been loaded.
- R2: When `src_load` is 1 at a source clock edge while `src_busy` is 0, the word on `src_data` is accepted, and `src_busy` is 1 after that edge.
- R3: When `src_load` is 1 at an edge while `src_busy` is 1, the word is discarded and never reaches the destination. `src_overrun` becomes 1 and stays 1 until the source reset.
- R4: Every accepted word appears on `dst_data` exactly once, unchanged, in acceptance order. Each appearance is marked by `dst_valid` high for exactly one destination clock cycle.
- R5: `src_busy` stays 1 until the acknowledge has crossed back and been turned into a pulse in the source domain. The first load after `src_busy` returns to 0 is accepted.
- R6: The held crossing word does not change while `src_busy` is 1.
- R7: Transfers are correct with the source clock three times faster than the destination clock, three times slower, and nearly equal with drifting phase.
- R8: `dst_data` changes only in the cycle where `dst_valid` is 1, and holds its value between transfers.
- R9: Every control level entering a domain passes through at least two flops in that domain before use. The parameter `SYNC_STAGES` must be 2 or more, and `DATA_W` must be 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_load | input | 1 | Request to send `src_data` |
| src_data | input | DATA_W | Word to be sent |
| src_busy | output | 1 | Transfer in flight; loads are refused |
| src_overrun | output | 1 | Sticky flag: a load was refused |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_data | output | DATA_W | Last word received |
| dst_valid | output | 1 | One-cycle marker of a new `dst_data` |

## Verification
Two source events can meet on a single edge: the acknowledge pulse that retires a transfer, and a new load request. Because `src_busy` is still 1 on that edge, the load must be refused and flagged, and only a load on the next edge may be taken. The bench provokes this by holding `src_load` high through a whole transfer with a second word on the bus. It then checks that the destination receives the first word and the second word exactly once each, and that `src_overrun` is set.

// File: rtl/cdc_hs_pkg.sv
package cdc_hs_pkg;
   // fewest flops allowed in a level synchronizer
   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_edge_pulse.sv
module hs_edge_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic history;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) history <= 1'b0;
      else        history <= level;
   end

   assign pulse = level ^ history;
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              ack_pulse,
   output logic              busy,
   output logic              overrun,
   output logic [DATA_W-1:0] hold_data,
   output logic              req_tgl
);
   logic accept;
   assign accept = load && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         overrun   <= 1'b0;
         hold_data <= '0;
         req_tgl   <= 1'b0;
      end else begin
         if (accept) begin
            hold_data <= din;
            req_tgl   <= ~req_tgl;
            busy      <= 1'b1;
         end else if (ack_pulse) begin
            busy      <= 1'b0;
         end
         if (load && busy) overrun <= 1'b1;
      end
   end

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |=> (busy && (req_tgl != $past(req_tgl))));
   assert_refuse_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && busy) |=> overrun);
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(hold_data) && $stable(req_tgl)));
   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ack_pulse) |=> busy);
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_pulse,
   input  logic [DATA_W-1:0] hold_data,
   output logic [DATA_W-1:0] dout,
   output logic              valid,
   output logic              ack_tgl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         valid   <= 1'b0;
         ack_tgl <= 1'b0;
      end else begin
         valid <= req_pulse;
         if (req_pulse) begin
            dout    <= hold_data;
            ack_tgl <= ~ack_tgl;
         end
      end
   end

   assert_single_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_ack_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tgl != $past(ack_tgl)) |-> valid);
   assert_dout_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> valid);
endmodule

// File: rtl/cdc_toggle_handshake.sv
module cdc_toggle_handshake #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic              src_load,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_busy,
   output logic              src_overrun,
   input  logic              dst_clk,
   input  logic              dst_rst_n,
   output logic [DATA_W-1:0] dst_data,
   output logic              dst_valid
);
   import cdc_hs_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("SYNC_STAGES must be at least %0d (R9)", MIN_SYNC_STAGES);
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1 (R9)");
   end

   logic [DATA_W-1:0] hold_data;
   logic              req_tgl, req_in_dst, req_pulse;
   logic              ack_tgl, ack_in_src, ack_pulse;

   hs_src_ctrl #(.DATA_W(DATA_W)) i_src (
      .clk(src_clk), .rst_n(src_rst_n), .load(src_load), .din(src_data),
      .ack_pulse(ack_pulse), .busy(src_busy), .overrun(src_overrun),
      .hold_data(hold_data), .req_tgl(req_tgl)
   );

   hs_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_in_dst)
   );
   hs_edge_pulse i_req_pulse (
      .clk(dst_clk), .rst_n(dst_rst_n), .level(req_in_dst), .pulse(req_pulse)
   );

   hs_dst_ctrl #(.DATA_W(DATA_W)) i_dst (
      .clk(dst_clk), .rst_n(dst_rst_n), .req_pulse(req_pulse),
      .hold_data(hold_data), .dout(dst_data), .valid(dst_valid),
      .ack_tgl(ack_tgl)
   );

   hs_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
      .clk(src_clk), .rst_n(src_rst_n), .d(ack_tgl), .q(ack_in_src)
   );
   hs_edge_pulse i_ack_pulse (
      .clk(src_clk), .rst_n(src_rst_n), .level(ack_in_src), .pulse(ack_pulse)
   );

   assert_ack_only_busy_R5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      ack_pulse |-> src_busy);
endmodule

// File: tb/test_cdc_toggle_handshake.sv
`timescale 1ns/1ps
module test_cdc_toggle_handshake;
   localparam int  DATA_W     = 8;
   localparam real SRC_PERIOD = 10.0;
   localparam int  NWORDS     = 12;
   localparam logic [DATA_W-1:0] WORDS [NWORDS] = '{
      8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80,
      8'h3C, 8'hC3, 8'h7E, 8'h81, 8'h55, 8'hAA};
   localparam logic [DATA_W-1:0] JUNK = 8'hEE;

   logic src_clk = 0, dst_clk = 0;
   logic src_rst_n = 0, dst_rst_n = 0;
   logic src_load = 0;
   logic [DATA_W-1:0] src_data = '0;
   logic src_busy, src_overrun, dst_valid;
   logic [DATA_W-1:0] dst_data;

   real dst_period = 30.0;
   int  checks = 0, errors = 0;
   logic [DATA_W-1:0] expq [$];
   int  sent = 0, rcvd = 0;
   logic prev_valid = 0;
   logic [DATA_W-1:0] prev_data = '0;
   logic done = 0;

   always #(SRC_PERIOD/2.0) src_clk = ~src_clk;
   always #(dst_period/2.0) dst_clk = ~dst_clk;

   cdc_toggle_handshake #(.DATA_W(DATA_W), .SYNC_STAGES(2)) i_cdc_toggle_handshake (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
      .src_data(src_data), .src_busy(src_busy), .src_overrun(src_overrun),
      .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_data(dst_data),
      .dst_valid(dst_valid));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // destination scoreboard (R4, R8)
   always @(negedge dst_clk) begin
      if (dst_rst_n) begin
         if (dst_valid) begin
            check(!prev_valid, "R4 valid one cycle", 1, 0);
            if (expq.size() == 0) begin
               check(0, "R4/R3 unexpected word", dst_data, 0);
            end else begin
               check(dst_data == expq[0], "R4/R7 word order", dst_data, expq[0]);
               void'(expq.pop_front());
            end
            rcvd++;
         end else begin
            if (dst_data != prev_data) check(0, "R8 data held", dst_data, prev_data);
         end
         prev_valid = dst_valid;
         prev_data  = dst_data;
      end
   end

   task automatic send(input logic [DATA_W-1:0] w);
      @(negedge src_clk);
      while (src_busy) @(negedge src_clk);
      src_load = 1; src_data = w;
      expq.push_back(w); sent++;
      @(negedge src_clk);
      src_load = 0;
      check(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
   endtask

   task automatic drain();
      int n = 0;
      while ((expq.size() != 0 || src_busy) && n < 5000) begin
         @(negedge src_clk); n++;
      end
      check(expq.size() == 0, "R7 all words arrived", expq.size(), 0);
      check(src_busy == 1'b0, "R5 busy released", src_busy, 0);
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 150000) begin @(posedge src_clk); cyc++; end
      if (!done) begin
         check(0, "watchdog", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge src_clk);
      src_rst_n = 1; dst_rst_n = 1;
      @(negedge src_clk);
      check(src_busy == 0, "R1 busy reset", src_busy, 0);
      check(src_overrun == 0, "R1 overrun reset", src_overrun, 0);
      check(dst_valid == 0, "R1 valid reset", dst_valid, 0);
      check(dst_data == '0, "R1 data reset", dst_data, 0);
      repeat (20) @(negedge src_clk);
      check(rcvd == 0, "R1 no spurious pulse", rcvd, 0);

      // R7: three clock ratios, table walked by one loop each
      for (int ph = 0; ph < 3; ph++) begin
         dst_period = (ph == 0) ? 30.0 : (ph == 1) ? 10.0/3.0 : 10.37;
         for (int i = 0; i < NWORDS; i++) send(WORDS[(i + ph) % NWORDS]);
         drain();
      end
      check(src_overrun == 0, "R3 no overrun without refusal", src_overrun, 0);

      // R3/R6: refused load while busy never reaches destination
      send(8'h42);
      src_load = 1; src_data = JUNK;
      @(negedge src_clk);
      src_load = 0;
      check(src_overrun == 1, "R3 overrun set", src_overrun, 1);
      drain();
      check(src_overrun == 1, "R3 overrun sticky", src_overrun, 1);

      // R5: load held high through the acknowledge edge
      @(negedge src_clk);
      src_load = 1; src_data = 8'h11;
      expq.push_back(8'h11); sent++;
      @(negedge src_clk);
      src_data = 8'h22;
      while (src_busy) @(negedge src_clk);
      expq.push_back(8'h22); sent++;
      @(negedge src_clk);
      src_load = 0;
      check(src_busy == 1, "R5 next load taken after release", src_busy, 1);
      drain();
      check(rcvd == sent, "R4 exactly once", rcvd, sent);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule